// File: doc/BRIEF.md
# Packed-Operand Decode and Address Generator

This block is the operand stage of a 32-bit processor. Each instruction word holds an 8-bit opcode in its top byte and a 24-bit operand in the bits below it. Registers and addresses are 32 bits wide, so the short operand field has to be widened before use. How it is widened depends on the opcode class:

- It can become a signed immediate.
- It can become an absolute address within the first 16M words of memory.
- It can become a signed offset from the program counter, with a reach of ±8M words.
- It can become a shift count.

The block takes the fetched word, the current program counter and a 3-bit class code from the decoder. It computes the widened value in a single combinational step and registers it. The execute stage reads the result one cycle later. A branch-to-subroutine also gets its return address here. Constants or addresses that need all 32 bits are not in scope. Software builds those in a register or reaches them through memory.

Top module: `opnd_stage`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it is released with no valid input, out_valid, out_opcode, out_class, out_value, out_link and out_shamt are all zero.
- R2: out_valid equals the in_valid value sampled at the previous rising edge. While in_valid is low, out_opcode, out_class, out_value, out_link and out_shamt keep their values.
- R3: For an accepted word, out_opcode is instr[31:24] and out_class is op_class, one cycle later.
- R4: Class 1 (immediate): out_value is instr[23:0] sign-extended from bit 23 to 32 bits.
- R5: Class 2 (direct): out_value is instr[23:0] zero-extended, so only word addresses 0 to 0x00FFFFFF are reachable.
- R6: Class 3 (branch): out_value is pc + 1 + sign-extended instr[23:0], taken modulo 2^32. The base is the word after the current one.
- R7: Class 4 (branch to subroutine): out_value is formed exactly as in R6, and out_link is pc + 1 modulo 2^32.
- R8: Classes 5 (load effective address) and 6 (push effective address): out_value is formed exactly as in R6.
- R9: Class 7 (shift or rotate): out_shamt is instr[4:0], a count of 0 means no shift, and out_value is zero.
- R10: Class 0 (register-only operation): the operand bits instr[23:0] are ignored, and out_value, out_link and out_shamt are zero.
- R11: out_shamt is zero in every class other than 7, and out_link is zero in every class other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetched word is present this cycle |
| instr | input | 32 | Instruction word: opcode in [31:24], operand in [23:0] |
| pc | input | 32 | Word address of the instruction |
| op_class | input | 3 | Operand class from the decoder (encoding in R4 to R10) |
| out_valid | output | 1 | Registered result is valid |
| out_opcode | output | 8 | Registered opcode byte |
| out_class | output | 3 | Registered class code |
| out_value | output | 32 | Immediate, direct address or PC-relative target |
| out_link | output | 32 | Return address for branch to subroutine |
| out_shamt | output | 5 | Shift count for shift and rotate classes |

## Verification
The bench builds the block with its default widths: a 32-bit word and an 8-bit opcode. With these widths it can reach the extreme operand values, 0x7FFFFF and 0x800000, and so exercise the full ±8M relative reach. It can also reach the wrap of PC-relative sums past 0xFFFFFFFF, and a 5-bit shift field whose upper operand bits must be dropped. Checks at the extremes of sign extension confirm that bit 23 alone selects the fill. Register-only words that carry different garbage in their operand field all give the same zero outputs.

// File: rtl/opnd_stage.sv
module opnd_stage #(
  parameter int WORD_W = 32,
  parameter int OPC_W = 8,
  localparam int SH_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc,
  input  logic [2:0]        op_class,
  output logic              out_valid,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [2:0]        out_class,
  output logic [WORD_W-1:0] out_value,
  output logic [WORD_W-1:0] out_link,
  output logic [SH_W-1:0]   out_shamt
);
  localparam int OPD_W = WORD_W - OPC_W;

  localparam logic [2:0] C_REG    = 3'd0;
  localparam logic [2:0] C_IMM    = 3'd1;
  localparam logic [2:0] C_DIRECT = 3'd2;
  localparam logic [2:0] C_BRANCH = 3'd3;
  localparam logic [2:0] C_BSR    = 3'd4;
  localparam logic [2:0] C_LEA    = 3'd5;
  localparam logic [2:0] C_PEA    = 3'd6;
  localparam logic [2:0] C_SHIFT  = 3'd7;

  logic [OPD_W-1:0]  opd;
  logic [WORD_W-1:0] opd_sx, opd_zx, next_pc, rel_tgt;
  logic [WORD_W-1:0] value_d, link_d;
  logic [SH_W-1:0]   shamt_d;

  assign opd     = instr[OPD_W-1:0];
  assign opd_sx  = {{OPC_W{opd[OPD_W-1]}}, opd};
  assign opd_zx  = {{OPC_W{1'b0}}, opd};
  assign next_pc = pc + WORD_W'(1);
  assign rel_tgt = next_pc + opd_sx;

  always_comb begin
    value_d = '0;
    link_d  = '0;
    shamt_d = '0;
    unique case (op_class)
      C_IMM:                value_d = opd_sx;
      C_DIRECT:             value_d = opd_zx;
      C_BRANCH, C_LEA, C_PEA: value_d = rel_tgt;
      C_BSR: begin
        value_d = rel_tgt;
        link_d  = next_pc;
      end
      C_SHIFT:              shamt_d = opd[SH_W-1:0];
      C_REG:                ;
      default:              ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_opcode <= '0;
      out_class  <= '0;
      out_value  <= '0;
      out_link   <= '0;
      out_shamt  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_opcode <= instr[WORD_W-1:OPD_W];
        out_class  <= op_class;
        out_value  <= value_d;
        out_link   <= link_d;
        out_shamt  <= shamt_d;
      end
    end
  end
endmodule

module opnd_stage_chk #(
  parameter int WORD_W = 32,
  parameter int OPC_W = 8,
  localparam int SH_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] pc,
  input logic [2:0]        op_class,
  input logic              out_valid,
  input logic [OPC_W-1:0]  out_opcode,
  input logic [2:0]        out_class,
  input logic [WORD_W-1:0] out_value,
  input logic [WORD_W-1:0] out_link,
  input logic [SH_W-1:0]   out_shamt
);
  localparam int OPD_W = WORD_W - OPC_W;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_link) && $stable(out_shamt)));
  // R3
  opcode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_opcode == $past(instr[WORD_W-1:OPD_W]) && out_class == $past(op_class)));
  // R4
  imm_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd1) |=> (out_value[OPD_W-1:0] == $past(instr[OPD_W-1:0])
      && (out_value[WORD_W-1:OPD_W] == '0 || out_value[WORD_W-1:OPD_W] == '1)));
  // R7
  bsr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd4) |=> (out_link == $past(pc) + WORD_W'(1)));
  // R9
  shift_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd7) |=> (out_shamt == $past(instr[SH_W-1:0]) && out_value == '0));
  // R10
  reg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd0) |=> (out_value == '0 && out_link == '0 && out_shamt == '0));
  // R11
  side_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class != 3'd7) |-> out_shamt == '0);
endmodule

bind opnd_stage opnd_stage_chk #(.WORD_W(WORD_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/opnd_stage_bench.sv
`timescale 1ns/1ps
module opnd_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [2:0]  op_class = '0;
  logic        out_valid;
  logic [7:0]  out_opcode;
  logic [2:0]  out_class;
  logic [31:0] out_value, out_link;
  logic [4:0]  out_shamt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opnd_stage u_opnd_stage (.*);

  function automatic logic [31:0] sx(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [31:0] w, input logic [31:0] p);
    @(negedge clk);
    in_valid = 1'b1; op_class = c; instr = w; pc = p;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", {31'b0, out_valid}, 0);
    check("R1 value", out_value, 0);
    check("R1 link", out_link, 0);
    check("R1 shamt", {27'b0, out_shamt}, 0);
    check("R1 opcode", {24'b0, out_opcode}, 0);
  endtask

  task automatic t_imm;
    issue(3'd1, 32'hA5_123456, 32'h0);
    check("R4 pos", out_value, 32'h00123456);
    check("R3 opcode", {24'b0, out_opcode}, 32'hA5);
    check("R3 class", {29'b0, out_class}, 1);
    check("R2 valid", {31'b0, out_valid}, 1);
    issue(3'd1, 32'h01_800000, 32'h0);
    check("R4 minneg", out_value, 32'hFF800000);
    issue(3'd1, 32'h01_FFFFFF, 32'h0);
    check("R4 minus1", out_value, 32'hFFFFFFFF);
    issue(3'd1, 32'h01_7FFFFF, 32'h0);
    check("R4 maxpos", out_value, 32'h007FFFFF);
  endtask

  task automatic t_direct;
    issue(3'd2, 32'h22_FFFFFF, 32'h5000);
    check("R5 top", out_value, 32'h00FFFFFF);
    issue(3'd2, 32'h22_800001, 32'h5000);
    check("R5 hi", out_value, 32'h00800001);
  endtask

  task automatic t_branch;
    issue(3'd3, 32'h30_FFFFFF, 32'h1000);
    check("R6 back1", out_value, 32'h1000);
    issue(3'd3, 32'h30_7FFFFF, 32'h1000);
    check("R6 fwdmax", out_value, 32'h1000 + 1 + 32'h7FFFFF);
    issue(3'd3, 32'h30_800000, 32'h10);
    check("R6 backmax", out_value, 32'h10 + 1 + sx(24'h800000));
    issue(3'd3, 32'h30_000000, 32'hFFFFFFFF);
    check("R6 wrap", out_value, 32'h0);
    check("R11 link", out_link, 0);
  endtask

  task automatic t_bsr;
    issue(3'd4, 32'h40_000010, 32'h00ABCDEF);
    check("R7 target", out_value, 32'h00ABCDEF + 1 + 32'h10);
    check("R7 link", out_link, 32'h00ABCDF0);
    check("R11 shamt", {27'b0, out_shamt}, 0);
  endtask

  task automatic t_ea;
    issue(3'd5, 32'h50_FFFF00, 32'h200);
    check("R8 lea", out_value, 32'h200 + 1 + sx(24'hFFFF00));
    issue(3'd6, 32'h60_000100, 32'hFFFFFF80);
    check("R8 pea", out_value, 32'hFFFFFF80 + 1 + 32'h100);
  endtask

  task automatic t_shift;
    issue(3'd7, 32'h70_000000, 32'h9);
    check("R9 zero", {27'b0, out_shamt}, 0);
    issue(3'd7, 32'h70_00001F, 32'h9);
    check("R9 max", {27'b0, out_shamt}, 31);
    issue(3'd7, 32'h70_FFFFE5, 32'h9);
    check("R9 upper", {27'b0, out_shamt}, 5);
    check("R9 value", out_value, 0);
    check("R11 link", out_link, 0);
  endtask

  task automatic t_regop;
    issue(3'd1, 32'h01_123456, 32'h0);
    issue(3'd0, 32'h80_FFFFFF, 32'h4444);
    check("R10 value", out_value, 0);
    check("R10 link", out_link, 0);
    check("R10 shamt", {27'b0, out_shamt}, 0);
    issue(3'd0, 32'h80_5A5A5A, 32'h0);
    check("R10 value2", out_value, 0);
  endtask

  task automatic t_hold;
    issue(3'd2, 32'h22_000777, 32'h0);
    @(negedge clk);
    instr = 32'h22_111111; op_class = 3'd1;
    @(posedge clk); #1;
    check("R2 idle valid", {31'b0, out_valid}, 0);
    check("R2 hold value", out_value, 32'h00000777);
    check("R2 hold class", {29'b0, out_class}, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_imm();
    t_direct();
    t_branch();
    t_bsr();
    t_ea();
    t_shift();
    t_regop();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule